// File: doc/BRIEF.md
# Dual Event Counter with Split and Cascade Modes

The block holds two 8-bit up-counters, a low half and a high half. In split mode each half counts events from its own source. That source is either a divided system clock or an edge on that half's external event pin. In cascade mode the two halves form one 16-bit counter: the low half's wrap advances the high half. Divided clocks are not derived clocks. They are one-cycle enable pulses taken from a free-running prescaler, so the whole block runs on the single clock `clk_i`. Each event pin passes through two synchroniser flops before its edges are detected.

Two gate inputs control whether events reach the counters. While both gates are low, nothing counts. Each half has a run bit and a release bit. A half whose release bit is 0 is held at zero. Each half has a sticky overflow flag. A shared interrupt-request flag, combined with an enable bit, drives `irq_o`. Software configures and observes the block through a synchronous write port and a combinational read port.

Top module: `evt_cnt_pair`

## Requirements
- R1: After reset every register reads 0x00, both counts read 0x00 and `irq_o` is 0.
- R2: Register map. Address 0 is CFG: [1:0] low source, [3:2] low edge, [5:4] high source, [7:6] high edge. Address 1 is CTL: [0] split, [1] low run, [2] low release, [3] high run, [4] high release, [5] interrupt enable. Address 2 is STS: [0] low overflow, [1] high overflow, [2] interrupt request. Addresses 3 and 4 are the low and high counts, which are read-only.
- R3: Source encodings 01, 10 and 11 give one count event every 2, 4 or 8 clock cycles. Over any window whose length is a multiple of 8 cycles, a half therefore counts exactly window/2, window/4 or window/8. Each half uses its own field.
- R4: Source 00 counts edges of that half's pin. Edge encoding 00 counts rising edges, 01 falling, 10 both, and 11 rising. The pin is synchronised and counted within 3 cycles.
- R5: Events count only while `gate_a_i` or `gate_b_i` is high. While both are low, the counts hold.
- R6: A half with release 1 and run 0 holds its count.
- R7: A half with release 0 is forced to 0x00 and stays there.
- R8: In split mode, a half holding 0xFF that receives an event wraps to 0x00 and sets its own overflow flag.
- R9: In cascade mode (split 0), the high half advances only on the low half's wrap, and its own source field is ignored. The low overflow flag is never set. A high wrap sets the high overflow flag.
- R10: Any overflow sets the interrupt-request flag in the same cycle. `irq_o` equals that flag ANDed with the interrupt enable.
- R11: Status flags are sticky. Writing 0 to a flag bit clears it, and writing 1 has no effect. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_a_i | input | 1 | Count gate, first input |
| gate_b_i | input | 1 | Count gate, second input |
| pin_lo_i | input | 1 | External event pin for the low half |
| pin_hi_i | input | 1 | External event pin for the high half |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions treat both gates as synchronous to `clk_i`, and they assume the counts change only through events or release control, never through software writes. The bench therefore drives the gates, pins and bus only on falling edges. It changes the gates only while the run bits are off. It measures divided-clock counts over windows that are multiples of eight cycles, so the result does not depend on the prescaler phase. Pin pulses are four cycles high and four cycles low, and the bench lets them settle for six cycles before it stops counting. This keeps every edge clear of the synchroniser latency.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_DIV2 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_DIV8 = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE     = 2'b00,
    EDGE_FALL     = 2'b01,
    EDGE_BOTH     = 2'b10,
    EDGE_RISE_ALT = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic irq_en;
    logic rel_hi;
    logic run_hi;
    logic rel_lo;
    logic run_lo;
    logic split;
  } ctl_t;

  localparam int unsigned CTL_W       = $bits(ctl_t);
  localparam logic [2:0]  ADDR_CFG    = 3'd0;
  localparam logic [2:0]  ADDR_CTL    = 3'd1;
  localparam logic [2:0]  ADDR_STS    = 3'd2;
  localparam logic [2:0]  ADDR_CNT_LO = 3'd3;
  localparam logic [2:0]  ADDR_CNT_HI = 3'd4;
endpackage

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PRE_W-1:0] tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // tick_o[i] pulses once every 2**(i+1) cycles
  for (genvar i = 0; i < PRE_W; i++) begin : g_tick
    assign tick_o[i] = &cnt_q[i:0];
  end
endmodule

// File: rtl/evt_src.sv
module evt_src
  import evt_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  src_sel_e         src_i,
  input  edge_sel_e        edge_i,
  input  logic [PRE_W-1:0] tick_i,
  output logic             evt_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic cur, prev, rise, fall, pin_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign cur  = sh_q[SYNC_STAGES-1];
  assign prev = sh_q[SYNC_STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (edge_i)
      EDGE_FALL: pin_evt = fall;
      EDGE_BOTH: pin_evt = rise | fall;
      default:   pin_evt = rise;
    endcase
  end

  always_comb begin
    unique case (src_i)
      SRC_DIV2: evt_o = tick_i[0];
      SRC_DIV4: evt_o = tick_i[1];
      SRC_DIV8: evt_o = tick_i[2];
      default:  evt_o = pin_evt;
    endcase
  end
endmodule

// File: rtl/evt_half.sv
module evt_half #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             run_i,
  input  logic             rel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = rel_i & run_i & evt_i;
  assign wrap_o = step & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!rel_i) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair
  import evt_cnt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_a_i,
  input  logic              gate_b_i,
  input  logic              pin_lo_i,
  input  logic              pin_hi_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = DATA_W;
  localparam int unsigned PRE_W = 3;

  logic [DATA_W-1:0] cfg_q;
  ctl_t              ctl_q;
  logic              ovf_lo_q, ovf_hi_q, irq_flag_q;
  logic [PRE_W-1:0]  tick;
  logic              src_evt_lo, src_evt_hi, gate_en;
  logic              evt_lo, evt_hi, wrap_lo, wrap_hi;
  logic              ovf_lo_set, ovf_hi_set, sts_wr;
  logic [CNT_W-1:0]  cnt_lo, cnt_hi;

  evt_prescale #(.PRE_W(PRE_W)) i_prescale (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  evt_src #(.SYNC_STAGES(SYNC_STAGES), .PRE_W(PRE_W)) i_src_lo (
    .clk_i, .rst_ni, .pin_i(pin_lo_i),
    .src_i(src_sel_e'(cfg_q[1:0])), .edge_i(edge_sel_e'(cfg_q[3:2])),
    .tick_i(tick), .evt_o(src_evt_lo)
  );

  evt_src #(.SYNC_STAGES(SYNC_STAGES), .PRE_W(PRE_W)) i_src_hi (
    .clk_i, .rst_ni, .pin_i(pin_hi_i),
    .src_i(src_sel_e'(cfg_q[5:4])), .edge_i(edge_sel_e'(cfg_q[7:6])),
    .tick_i(tick), .evt_o(src_evt_hi)
  );

  assign gate_en = gate_a_i | gate_b_i;
  assign evt_lo  = src_evt_lo & gate_en;
  // cascade: high half steps on low wrap (already gated)
  assign evt_hi  = ctl_q.split ? (src_evt_hi & gate_en) : wrap_lo;

  evt_half #(.CNT_W(CNT_W)) i_half_lo (
    .clk_i, .rst_ni, .evt_i(evt_lo), .run_i(ctl_q.run_lo), .rel_i(ctl_q.rel_lo),
    .cnt_o(cnt_lo), .wrap_o(wrap_lo)
  );

  evt_half #(.CNT_W(CNT_W)) i_half_hi (
    .clk_i, .rst_ni, .evt_i(evt_hi), .run_i(ctl_q.run_hi), .rel_i(ctl_q.rel_hi),
    .cnt_o(cnt_hi), .wrap_o(wrap_hi)
  );

  assign ovf_lo_set = wrap_lo & ctl_q.split;
  assign ovf_hi_set = wrap_hi;
  assign sts_wr     = we_i && (addr_i == ADDR_W'(ADDR_STS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADDR_CFG)) cfg_q <= wdata_i;
      if (addr_i == ADDR_W'(ADDR_CTL)) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
    end
  end

  // sticky flags: set wins over a write-0 clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_lo_q   <= 1'b0;
      ovf_hi_q   <= 1'b0;
      irq_flag_q <= 1'b0;
    end else begin
      ovf_lo_q   <= ovf_lo_set | (ovf_lo_q & (~sts_wr | wdata_i[0]));
      ovf_hi_q   <= ovf_hi_set | (ovf_hi_q & (~sts_wr | wdata_i[1]));
      irq_flag_q <= ovf_lo_set | ovf_hi_set | (irq_flag_q & (~sts_wr | wdata_i[2]));
    end
  end

  assign irq_o = irq_flag_q & ctl_q.irq_en;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(ADDR_CFG):    rdata_o = cfg_q;
      ADDR_W'(ADDR_CTL):    rdata_o = DATA_W'(ctl_q);
      ADDR_W'(ADDR_STS):    rdata_o = DATA_W'({irq_flag_q, ovf_hi_q, ovf_lo_q});
      ADDR_W'(ADDR_CNT_LO): rdata_o = cnt_lo;
      ADDR_W'(ADDR_CNT_HI): rdata_o = cnt_hi;
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_cnt_pair_chk.sv
module evt_cnt_pair_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned CTL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_a_i,
  input logic             gate_b_i,
  input logic [CTL_W-1:0] ctl,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic             evt_hi,
  input logic             ovf_lo,
  input logic             ovf_hi,
  input logic             irq_flag
);
  AST_HELD_ZERO_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl[2] |=> cnt_lo == '0);  // R7
  AST_HELD_ZERO_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl[4] |=> cnt_hi == '0);  // R7
  AST_RUN_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[4] && !ctl[3]) |=> cnt_hi == $past(cnt_hi));  // R6
  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_a_i && !gate_b_i && ctl[2] && ctl[4])
      |=> (cnt_lo == $past(cnt_lo) && cnt_hi == $past(cnt_hi)));  // R5
  AST_STEP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_lo != $past(cnt_lo)) |-> (cnt_lo == $past(cnt_lo) + 1'b1 || cnt_lo == '0));  // R8
  AST_HI_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hi && ctl[3] && ctl[4] && cnt_hi == '1) |=> ovf_hi);  // R8
  AST_NO_LO_FLAG_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl[0] && !ovf_lo) |=> !ovf_lo);  // R9
  AST_OVF_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_lo) || $rose(ovf_hi)) |-> irq_flag);  // R10
endmodule

bind evt_cnt_pair evt_cnt_pair_chk #(.CNT_W(CNT_W), .CTL_W(evt_cnt_pkg::CTL_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_a_i (gate_a_i),
  .gate_b_i (gate_b_i),
  .ctl      (ctl_q),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .evt_hi   (evt_hi),
  .ovf_lo   (ovf_lo_q),
  .ovf_hi   (ovf_hi_q),
  .irq_flag (irq_flag_q)
);

// File: tb/test_evt_cnt_pair.sv
module test_evt_cnt_pair;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 3'd0, A_CTL = 3'd1, A_STS = 3'd2, A_LO = 3'd3, A_HI = 3'd4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       gate_a_i = 1'b1, gate_b_i = 1'b1, pin_lo_i = 1'b0, pin_hi_i = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  evt_cnt_pair i_evt_cnt_pair (
    .clk_i, .rst_ni, .gate_a_i, .gate_b_i, .pin_lo_i, .pin_hi_i,
    .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, int exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(req, int'(rdata_o), exp);
  endtask

  // ctl written with run bits on, then off after exactly n counting edges
  task automatic window(logic [7:0] ctl_run, logic [7:0] ctl_stop, int n);
    wr(A_CTL, ctl_run);
    repeat (n - 1) @(posedge clk_i);
    wr(A_CTL, ctl_stop);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 3'(a), 0);
    chk("R1 irq_o", int'(irq_o), 0);

    // R2 R3 divided sources, every pairing; R6 hold with run off
    for (int s = 1; s < 4; s++) begin
      int h = (s % 3) + 1;
      wr(A_CFG, 8'((h << 4) | s));
      rd_chk("R2 cfg readback", A_CFG, (h << 4) | s);
      wr(A_CTL, 8'h01);
      window(8'h1F, 8'h15, 64);
      rd_chk("R3 div lo", A_LO, 64 >> s);
      rd_chk("R3 div hi", A_HI, 64 >> h);
      repeat (10) @(negedge clk_i);
      rd_chk("R6 run off hold lo", A_LO, 64 >> s);
      rd_chk("R6 run off hold hi", A_HI, 64 >> h);
    end

    // R4 pin edges, all four edge codes on both halves
    for (int e = 0; e < 4; e++) begin
      int eh = 3 - e;
      wr(A_CFG, 8'((eh << 6) | (e << 2)));
      wr(A_CTL, 8'h01);
      wr(A_CTL, 8'h1F);
      for (int p = 0; p < 5; p++) begin
        @(negedge clk_i); pin_lo_i = 1'b1; pin_hi_i = 1'b1;
        repeat (4) @(negedge clk_i);
        pin_lo_i = 1'b0; pin_hi_i = 1'b0;
        repeat (3) @(negedge clk_i);
      end
      repeat (6) @(negedge clk_i);
      wr(A_CTL, 8'h15);
      rd_chk("R4 pin lo", A_LO, (e == 2) ? 10 : 5);
      rd_chk("R4 pin hi", A_HI, (eh == 2) ? 10 : 5);
    end

    // R5 gating
    wr(A_CFG, 8'h11);
    wr(A_CTL, 8'h01);
    wr(A_CTL, 8'h15);
    @(negedge clk_i); gate_a_i = 1'b0; gate_b_i = 1'b0;
    window(8'h1F, 8'h15, 64);
    rd_chk("R5 gates low lo", A_LO, 0);
    rd_chk("R5 gates low hi", A_HI, 0);
    @(negedge clk_i); gate_b_i = 1'b1;
    window(8'h1F, 8'h15, 64);
    rd_chk("R5 gate_b only", A_LO, 32);
    @(negedge clk_i); gate_a_i = 1'b1; gate_b_i = 1'b0;
    window(8'h1F, 8'h15, 64);
    rd_chk("R5 gate_a only", A_HI, 64);
    @(negedge clk_i); gate_b_i = 1'b1;

    // R7 release 0 forces zero while the other half counts
    window(8'h1B, 8'h15, 64);
    rd_chk("R7 lo forced zero", A_LO, 0);
    rd_chk("R7 hi keeps counting", A_HI, 96);

    // R8 wrap in split mode, R10 irq, R11 sticky clear
    wr(A_CFG, 8'h31);
    wr(A_CTL, 8'h01);
    window(8'h1F, 8'h15, 512);
    rd_chk("R8 lo wrapped", A_LO, 0);
    rd_chk("R8 hi div8", A_HI, 64);
    rd_chk("R8 sts lo flag", A_STS, 8'h05);
    chk("R10 irq_o masked", int'(irq_o), 0);
    wr(A_CTL, 8'h35);
    #1 chk("R10 irq_o enabled", int'(irq_o), 1);
    wr(A_STS, 8'hFF);
    rd_chk("R11 write 1 no effect", A_STS, 8'h05);
    wr(A_STS, 8'h00);
    rd_chk("R11 write 0 clears", A_STS, 0);
    #1 chk("R11 irq_o cleared", int'(irq_o), 0);

    // R9 cascade: hi source field (div8) ignored
    wr(A_CTL, 8'h00);
    window(8'h1E, 8'h14, 1024);
    rd_chk("R9 cascade lo", A_LO, 0);
    rd_chk("R9 cascade hi", A_HI, 2);
    rd_chk("R9 no lo flag", A_STS, 0);
    wr(A_CTL, 8'h00);
    window(8'h1E, 8'h14, 131072);
    rd_chk("R9 cascade wrap lo", A_LO, 0);
    rd_chk("R9 cascade wrap hi", A_HI, 0);
    rd_chk("R9 R10 hi flag and irq", A_STS, 8'h06);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule